// File: doc/BRIEF.md
# Alarm, Timer and Interrupt Unit

This unit sits next to a real-time clock's counter chain. It compares programmed alarm bytes against the live time counters and sets an alarm flag when they match. It also runs a two-digit BCD timer that advances on a tick of selectable resolution and sets a timer flag when it wraps. An active-low interrupt line is driven from the two flags and their enables.

Software sets up the unit through a one-byte alarm control word and an alarm-enable bit. Flags are changed by flag write strobes. The timer value is loaded through a write strobe. When the alarm-enable bit is clear, the alarm logic is idle and the interrupt line carries a 1 Hz square wave with 50% duty. This wave is derived from the hundredths counter.

Top module: `alarm_timer_irq`

## Requirements
- R1: After reset, `timer_q` is 0x00, both flags are 0, and `int_n` is 1.
- R2: With `alarm_en`=1, the timer advances by one in BCD on the tick chosen by `alm_ctl[2:0]`: 001 hundredths, 010 seconds, 011 minutes, 100 hours, 101 days. Codes 000, 110 and 111 select no tick. With `alarm_en`=0 the timer holds its value.
- R3: At 0x99 the timer's next step goes to 0x00 and sets `timer_flag` on the same edge. `tmr_wr` loads `tmr_wdata` and takes priority over a tick.
- R4: Daily alarm (`alm_ctl[5:4]`=01): the alarm matches when the hundredths, seconds, minutes and hours bytes equal their alarm bytes in all 8 bits.
- R5: Weekday alarm (10): the daily match applies, and in addition `al_month` bit w must be 1, where w = `cnt_wm[7:5]` is the weekday (0..6).
- R6: Dated alarm (11): the daily match applies, and in addition `cnt_yd[5:0]` equals `al_date[5:0]` and `cnt_wm[4:0]` equals `al_month[4:0]`. The year bits `cnt_yd[7:6]` and the weekday bits do not affect the match.
- R7: With `alm_ctl[6]`=1, the alarm flag is set when `timer_q` equals `al_timer`.
- R8: A match sets `alarm_flag` once, on the edge that ends the first cycle in which the match holds. A match that persists does not set the flag again after software clears it.
- R9: Flags hold until a flag write. A flag write stores `flag_wdata[1]` into the alarm flag and `flag_wdata[0]` into the timer flag. A write of 0 overrides a set event in the same cycle.
- R10: With `alarm_en`=1, `int_n` is 0 exactly when (`alarm_flag` and `alm_ctl[7]`) or (`timer_flag` and `alm_ctl[3]`).
- R11: With `alarm_en`=0, no flag is set by events. `int_n` is 1 one cycle after `cnt_hund` is below 0x50 and 0 one cycle after it is 0x50 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alarm_en | input | 1 | Alarm enable from control/status |
| alm_ctl | input | 8 | Alarm control byte |
| tick_hund | input | 1 | Hundredths tick pulse |
| tick_sec | input | 1 | Seconds tick pulse |
| tick_min | input | 1 | Minutes tick pulse |
| tick_hour | input | 1 | Hours tick pulse |
| tick_day | input | 1 | Days tick pulse |
| cnt_hund | input | 8 | Hundredths counter |
| cnt_sec | input | 8 | Seconds counter |
| cnt_min | input | 8 | Minutes counter |
| cnt_hour | input | 8 | Hours counter (format, AM/PM, BCD) |
| cnt_yd | input | 8 | Year (7:6) and date (5:0) |
| cnt_wm | input | 8 | Weekday (7:5) and month (4:0) |
| al_hund | input | 8 | Alarm hundredths |
| al_sec | input | 8 | Alarm seconds |
| al_min | input | 8 | Alarm minutes |
| al_hour | input | 8 | Alarm hours |
| al_date | input | 8 | Alarm date |
| al_month | input | 8 | Alarm month, or weekday mask |
| al_timer | input | 8 | Alarm timer value |
| tmr_wr | input | 1 | Timer load strobe |
| tmr_wdata | input | 8 | Timer load value |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 2 | Flag write data: bit1 alarm, bit0 timer |
| timer_q | output | 8 | Timer value |
| alarm_flag | output | 1 | Alarm flag |
| timer_flag | output | 1 | Timer flag |
| int_n | output | 1 | Active-low interrupt level |

## Verification
The daily alarm is first driven with date and month bytes that do not match. It fires anyway, which shows that those lanes are masked off. The weekday alarm is then driven against a mask with the current day cleared and then set; it stays quiet and then fires, which separates mask lookup from plain time matching. The dated alarm is driven with different year and weekday bits, and it must still fire. It is then driven with a different month, and it must not fire. Timer runs cross 0x09→0x10 and 0x99→0x00 under two resolutions, showing BCD carry, tick selection and wrap flagging. Clearing a flag while the match persists, and clearing one in the cycle of a set event, separate edge-triggered setting from level setting.

// File: rtl/atu_pkg.sv
`timescale 1ns/1ps
// Shared types for the alarm/timer/interrupt unit.
// Assumes byte-wide BCD counter and alarm registers.
package atu_pkg;
    localparam int BYTE_W  = 8;
    localparam int N_LANES = 6;   // hund, sec, min, hour, year/date, weekday/month

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        AK_NONE    = 2'b00,
        AK_DAILY   = 2'b01,
        AK_WEEKDAY = 2'b10,
        AK_DATED   = 2'b11
    } alarm_kind_e;

    typedef enum logic [2:0] {
        TR_OFF  = 3'b000,
        TR_HUND = 3'b001,
        TR_SEC  = 3'b010,
        TR_MIN  = 3'b011,
        TR_HOUR = 3'b100,
        TR_DAY  = 3'b101,
        TR_RSV6 = 3'b110,
        TR_RSV7 = 3'b111
    } tmr_res_e;

    // Alarm control byte, MSB first.
    typedef struct packed {
        logic        irq_alarm;   // bit 7
        logic        tmr_alarm;   // bit 6
        alarm_kind_e kind;        // bits 5:4
        logic        irq_timer;   // bit 3
        tmr_res_e    res;         // bits 2:0
    } alm_ctl_t;

    // One BCD increment of a two-digit value (legal input assumed).
    function automatic byte_t bcd_step(byte_t v);
        byte_t r;
        if (v[3:0] >= 4'd9) begin
            r[3:0] = 4'd0;
            r[7:4] = v[7:4] + 4'd1;
        end else begin
            r[3:0] = v[3:0] + 4'd1;
            r[7:4] = v[7:4];
        end
        return r;
    endfunction
endpackage

// File: rtl/atu_timer.sv
`timescale 1ns/1ps
// BCD timer 00..TOP with tick-resolution select and software load.
// Assumes ticks are single-cycle pulses and loads are legal BCD.
module atu_timer
    import atu_pkg::*;
#(
    parameter int    N_TICKS = 5,
    parameter byte_t TOP     = 8'h99
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  tmr_res_e           res,
    input  logic [N_TICKS-1:0] ticks,
    input  logic               wr,
    input  byte_t              wdata,
    output byte_t              q,
    output logic               wrap
);
    logic step;

    // Pick the tick matching the resolution code (code i+1 -> tick i).
    always_comb begin
        step = 1'b0;
        for (int i = 0; i < N_TICKS; i++) begin
            if (int'(res) == i + 1) step = ticks[i];
        end
        step = step & run;
    end

    // Wrap fires on a step from TOP unless a load overrides it.
    assign wrap = step && !wr && (q == TOP);

    // Timer register: load, wrap to zero, or BCD count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr) begin
            q <= wdata;
        end else if (step) begin
            q <= (q == TOP) ? '0 : bcd_step(q);
        end
    end
endmodule

// File: rtl/atu_match.sv
`timescale 1ns/1ps
// Alarm comparators with rising-edge hit detection.
// Clock alarm compares masked lanes; weekday kind also consults a day mask.
// Assumes the weekday field sits in bits 7:5 of the weekday/month lane.
module atu_match
    import atu_pkg::*;
#(
    parameter byte_t DATE_MASK  = 8'h3F,
    parameter byte_t MONTH_MASK = 8'h1F,
    parameter int    N_WDAYS    = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  alarm_kind_e kind,
    input  logic        tmr_alarm_en,
    input  byte_t       cnt [N_LANES],
    input  byte_t       al  [N_LANES],
    input  byte_t       tmr_q,
    input  byte_t       al_timer,
    output logic        clk_hit,
    output logic        tmr_hit
);
    localparam int WD_LANE = N_LANES - 1;
    localparam int YD_LANE = N_LANES - 2;

    logic [N_LANES-1:0] lane_eq;
    logic [2:0]         wday;
    logic               wday_ok;
    logic               clk_match, tmr_match;
    logic               clk_prev, tmr_prev;

    // Per-lane masked equality; mask depends on alarm kind.
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        byte_t msk;
        if (i == YD_LANE) begin : g_date
            assign msk = (kind == AK_DATED) ? DATE_MASK : '0;
        end else if (i == WD_LANE) begin : g_month
            assign msk = (kind == AK_DATED) ? MONTH_MASK : '0;
        end else begin : g_time
            assign msk = (kind != AK_NONE) ? '1 : '0;
        end
        assign lane_eq[i] = ((cnt[i] ^ al[i]) & msk) == '0;
    end

    assign wday = cnt[WD_LANE][7:5];

    // Weekday mask lookup, valid days only.
    always_comb begin
        wday_ok = 1'b0;
        if (int'(wday) < N_WDAYS) wday_ok = al[WD_LANE][wday];
    end

    // Clock and timer match levels.
    always_comb begin
        clk_match = enable && (kind != AK_NONE) && (&lane_eq)
                    && ((kind != AK_WEEKDAY) || wday_ok);
        tmr_match = enable && tmr_alarm_en && (tmr_q == al_timer);
    end

    // Remember last cycle's match levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_prev <= 1'b0;
            tmr_prev <= 1'b0;
        end else begin
            clk_prev <= clk_match;
            tmr_prev <= tmr_match;
        end
    end

    assign clk_hit = clk_match && !clk_prev;
    assign tmr_hit = tmr_match && !tmr_prev;
endmodule

// File: rtl/atu_flags.sv
`timescale 1ns/1ps
// Sticky alarm and timer flags; software write beats a same-cycle set.
module atu_flags (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       a_set,
    input  logic       t_set,
    input  logic       wr,
    input  logic [1:0] wdata,
    output logic       aflag,
    output logic       tflag
);
    // Flag registers: write has priority, else set events latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aflag <= 1'b0;
            tflag <= 1'b0;
        end else if (wr) begin
            aflag <= wdata[1];
            tflag <= wdata[0];
        end else begin
            if (a_set) aflag <= 1'b1;
            if (t_set) tflag <= 1'b1;
        end
    end
endmodule

// File: rtl/atu_irq.sv
`timescale 1ns/1ps
// Interrupt level: flag/enable OR when alarms on, else 1 Hz square wave
// taken from the hundredths count (high for the first half second).
module atu_irq
    import atu_pkg::*;
#(
    parameter byte_t HALF_SEC = 8'h50
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  alarm_en,
    input  byte_t cnt_hund,
    input  logic  aflag,
    input  logic  tflag,
    input  logic  irq_alarm,
    input  logic  irq_timer,
    output logic  int_n
);
    logic sq_q;

    // Square-wave register, high below the half-second mark.
    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= 1'b1;
        else        sq_q <= (cnt_hund < HALF_SEC);
    end

    // Output selection.
    always_comb begin
        if (alarm_en) int_n = !((aflag && irq_alarm) || (tflag && irq_timer));
        else          int_n = sq_q;
    end
endmodule

// File: rtl/alarm_timer_irq.sv
`timescale 1ns/1ps
// Top of the alarm/timer/interrupt unit. Packs counter and alarm bytes
// into lanes, runs the timer, detects alarm edges, keeps flags and drives
// the interrupt. Assumes counters change only on their tick cycles.
module alarm_timer_irq
    import atu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alarm_en,
    input  logic [7:0] alm_ctl,
    input  logic       tick_hund,
    input  logic       tick_sec,
    input  logic       tick_min,
    input  logic       tick_hour,
    input  logic       tick_day,
    input  logic [7:0] cnt_hund,
    input  logic [7:0] cnt_sec,
    input  logic [7:0] cnt_min,
    input  logic [7:0] cnt_hour,
    input  logic [7:0] cnt_yd,
    input  logic [7:0] cnt_wm,
    input  logic [7:0] al_hund,
    input  logic [7:0] al_sec,
    input  logic [7:0] al_min,
    input  logic [7:0] al_hour,
    input  logic [7:0] al_date,
    input  logic [7:0] al_month,
    input  logic [7:0] al_timer,
    input  logic       tmr_wr,
    input  logic [7:0] tmr_wdata,
    input  logic       flag_wr,
    input  logic [1:0] flag_wdata,
    output logic [7:0] timer_q,
    output logic       alarm_flag,
    output logic       timer_flag,
    output logic       int_n
);
    localparam int N_TICKS = 5;

    alm_ctl_t           ctl;
    byte_t              cnt_l [N_LANES];
    byte_t              al_l  [N_LANES];
    logic [N_TICKS-1:0] ticks;
    logic               wrap, clk_hit, tmr_hit;

    assign ctl   = alm_ctl_t'(alm_ctl);
    assign ticks = {tick_day, tick_hour, tick_min, tick_sec, tick_hund};

    // Lane packing in counter order.
    always_comb begin
        cnt_l[0] = cnt_hund;  al_l[0] = al_hund;
        cnt_l[1] = cnt_sec;   al_l[1] = al_sec;
        cnt_l[2] = cnt_min;   al_l[2] = al_min;
        cnt_l[3] = cnt_hour;  al_l[3] = al_hour;
        cnt_l[4] = cnt_yd;    al_l[4] = al_date;
        cnt_l[5] = cnt_wm;    al_l[5] = al_month;
    end

    atu_timer #(.N_TICKS(N_TICKS), .TOP(8'h99)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (alarm_en),
        .res   (ctl.res),
        .ticks (ticks),
        .wr    (tmr_wr),
        .wdata (tmr_wdata),
        .q     (timer_q),
        .wrap  (wrap)
    );

    atu_match #(.DATE_MASK(8'h3F), .MONTH_MASK(8'h1F), .N_WDAYS(7)) u_match (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (alarm_en),
        .kind         (ctl.kind),
        .tmr_alarm_en (ctl.tmr_alarm),
        .cnt          (cnt_l),
        .al           (al_l),
        .tmr_q        (timer_q),
        .al_timer     (al_timer),
        .clk_hit      (clk_hit),
        .tmr_hit      (tmr_hit)
    );

    atu_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .a_set (clk_hit || tmr_hit),
        .t_set (wrap),
        .wr    (flag_wr),
        .wdata (flag_wdata),
        .aflag (alarm_flag),
        .tflag (timer_flag)
    );

    atu_irq #(.HALF_SEC(8'h50)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .alarm_en  (alarm_en),
        .cnt_hund  (cnt_hund),
        .aflag     (alarm_flag),
        .tflag     (timer_flag),
        .irq_alarm (ctl.irq_alarm),
        .irq_timer (ctl.irq_timer),
        .int_n     (int_n)
    );
endmodule

// File: rtl/atu_checker.sv
`timescale 1ns/1ps
// Temporal checks on the unit's ports, bound to the top module.
module atu_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       alarm_en,
    input logic [7:0] alm_ctl,
    input logic       tick_hund,
    input logic       tick_sec,
    input logic       tick_min,
    input logic       tick_hour,
    input logic       tick_day,
    input logic [7:0] cnt_hund,
    input logic       tmr_wr,
    input logic       flag_wr,
    input logic [1:0] flag_wdata,
    input logic [7:0] timer_q,
    input logic       alarm_flag,
    input logic       timer_flag,
    input logic       int_n
);
    // R2
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_wr && !(tick_hund || tick_sec || tick_min || tick_hour || tick_day))
        |=> $stable(timer_q));

    // R3
    tmr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && !tmr_wr && !flag_wr && tick_hund && alm_ctl[2:0] == 3'b001
         && timer_q == 8'h99) |=> (timer_flag && timer_q == 8'h00));

    // R9
    aflag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_wr) |=> alarm_flag);

    // R9
    tflag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_flag && !flag_wr) |=> timer_flag);

    // R9
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_wr && !flag_wdata[1]) |=> !alarm_flag);

    // R10
    irq_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && alm_ctl[7] && alarm_flag) |-> !int_n);

    // R11
    sq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_en && cnt_hund < 8'h50) |=> (int_n || alarm_en));

    // R11
    sq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_en && cnt_hund >= 8'h50) |=> (!int_n || alarm_en));
endmodule

bind alarm_timer_irq atu_checker u_chk (.*);

// File: tb/alarm_timer_irq_test.sv
`timescale 1ns/1ps
module alarm_timer_irq_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, alarm_en, tick_hund, tick_sec, tick_min, tick_hour, tick_day;
    logic [7:0] alm_ctl, cnt_hund, cnt_sec, cnt_min, cnt_hour, cnt_yd, cnt_wm;
    logic [7:0] al_hund, al_sec, al_min, al_hour, al_date, al_month, al_timer;
    logic       tmr_wr, flag_wr;
    logic [7:0] tmr_wdata;
    logic [1:0] flag_wdata;
    logic [7:0] timer_q;
    logic       alarm_flag, timer_flag, int_n;

    alarm_timer_irq uut (.*);

    int    compared = 0, mismatched = 0;
    bit    done = 0;
    string tag = "R1";

    // reference model state
    logic [7:0] m_tmr;
    logic       m_af, m_tf, m_pc, m_pt, m_sq;

    function automatic logic [7:0] dec_inc(logic [7:0] v);
        int d;
        d = int'(v[7:4]) * 10 + int'(v[3:0]) + 1;
        return {4'(d / 10), 4'(d % 10)};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic model_int();
        if (!alarm_en) return m_sq;
        return !((m_af && alm_ctl[7]) || (m_tf && alm_ctl[3]));
    endfunction

    // One cycle: compare at mid-low phase, then advance the model.
    task automatic step();
        logic tsel, ovf, daily, mc, tm, aset;
        logic [7:0] nt;
        int wd;
        #1;
        chk(tag, timer_q, m_tmr);
        chk(tag, {7'd0, alarm_flag}, {7'd0, m_af});
        chk(tag, {7'd0, timer_flag}, {7'd0, m_tf});
        chk(tag, {7'd0, int_n}, {7'd0, model_int()});
        case (alm_ctl[2:0])
            3'd1: tsel = tick_hund;
            3'd2: tsel = tick_sec;
            3'd3: tsel = tick_min;
            3'd4: tsel = tick_hour;
            3'd5: tsel = tick_day;
            default: tsel = 1'b0;
        endcase
        tsel = tsel && alarm_en;
        ovf = 1'b0;
        nt = m_tmr;
        if (tmr_wr) nt = tmr_wdata;
        else if (tsel) begin
            if (m_tmr == 8'h99) begin nt = 8'h00; ovf = 1'b1; end
            else nt = dec_inc(m_tmr);
        end
        daily = cnt_hund == al_hund && cnt_sec == al_sec && cnt_min == al_min
                && cnt_hour == al_hour;
        wd = int'(cnt_wm[7:5]);
        case (alm_ctl[5:4])
            2'd1: mc = daily;
            2'd2: mc = daily && wd < 7 && al_month[wd];
            2'd3: mc = daily && cnt_yd[5:0] == al_date[5:0] && cnt_wm[4:0] == al_month[4:0];
            default: mc = 1'b0;
        endcase
        mc = mc && alarm_en;
        tm = alarm_en && alm_ctl[6] && m_tmr == al_timer;
        aset = (mc && !m_pc) || (tm && !m_pt);
        if (flag_wr) begin m_af = flag_wdata[1]; m_tf = flag_wdata[0]; end
        else begin
            if (aset) m_af = 1'b1;
            if (ovf)  m_tf = 1'b1;
        end
        m_pc = mc; m_pt = tm; m_tmr = nt;
        m_sq = cnt_hund < 8'h50;
        @(negedge clk);
        tmr_wr = 0; flag_wr = 0;
        {tick_hund, tick_sec, tick_min, tick_hour, tick_day} = '0;
    endtask

    task automatic clear_flags();
        flag_wr = 1; flag_wdata = 2'b00; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 0; alarm_en = 0; alm_ctl = 0;
        {tick_hund, tick_sec, tick_min, tick_hour, tick_day} = '0;
        cnt_hund = 0; cnt_sec = 0; cnt_min = 0; cnt_hour = 0; cnt_yd = 8'h01; cnt_wm = 8'h01;
        al_hund = 8'h77; al_sec = 0; al_min = 0; al_hour = 0; al_date = 0; al_month = 0; al_timer = 0;
        tmr_wr = 0; tmr_wdata = 0; flag_wr = 0; flag_wdata = 0;
        m_tmr = 0; m_af = 0; m_tf = 0; m_pc = 0; m_pt = 0; m_sq = 1;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        tag = "R1";
        #1;
        chk("R1", timer_q, 8'h00); chk("R1", {7'd0, alarm_flag}, 8'h00);
        chk("R1", {7'd0, timer_flag}, 8'h00); chk("R1", {7'd0, int_n}, 8'h01);
        @(negedge clk);

        // R11 square wave and idle timer while alarms are off
        tag = "R11";
        alm_ctl = 8'h09;
        cnt_hund = 8'h49; tick_hund = 1; step(); step();
        chk("R11", {7'd0, int_n}, 8'h01);
        chk("R11", timer_q, 8'h00);
        cnt_hund = 8'h50; step(); step();
        chk("R11", {7'd0, int_n}, 8'h00);
        cnt_hund = 8'h99; step(); cnt_hund = 8'h00; step(); step();
        chk("R11", {7'd0, int_n}, 8'h01);

        // R2 and R3 hundredths timer: BCD carry and wrap
        tag = "R2";
        alarm_en = 1;
        tmr_wr = 1; tmr_wdata = 8'h09; step();
        tick_hund = 1; step();
        chk("R2", timer_q, 8'h10);
        tag = "R3";
        tmr_wr = 1; tmr_wdata = 8'h98; tick_hund = 1; step();
        chk("R3", timer_q, 8'h98);
        tick_hund = 1; step(); tick_hund = 1; step();
        chk("R3", timer_q, 8'h00); chk("R3", {7'd0, timer_flag}, 8'h01);
        chk("R10", {7'd0, int_n}, 8'h00);

        // R9 clear, then clear colliding with wrap
        tag = "R9";
        clear_flags();
        chk("R9", {7'd0, timer_flag}, 8'h00);
        tmr_wr = 1; tmr_wdata = 8'h99; step();
        tick_hund = 1; flag_wr = 1; flag_wdata = 2'b00; step();
        chk("R9", timer_q, 8'h00); chk("R9", {7'd0, timer_flag}, 8'h00);

        // R2 seconds resolution ignores hundredths ticks
        tag = "R2";
        alm_ctl = 8'h02;
        tick_hund = 1; step(); tick_hund = 1; step();
        chk("R2", timer_q, 8'h00);
        tick_sec = 1; step();
        chk("R2", timer_q, 8'h01);
        alm_ctl = 8'h06;
        tick_hund = 1; tick_sec = 1; step();
        chk("R2", timer_q, 8'h01);

        // R4 daily alarm with non-matching date/month
        tag = "R4";
        cnt_hund = 8'h12; cnt_sec = 8'h34; cnt_min = 8'h56; cnt_hour = 8'h87;
        cnt_yd = 8'h15; cnt_wm = 8'h63;
        al_hund = 8'h12; al_sec = 8'h34; al_min = 8'h56; al_hour = 8'h87;
        al_date = 8'h00; al_month = 8'h00;
        alm_ctl = 8'h90;
        step(); step();
        chk("R4", {7'd0, alarm_flag}, 8'h01);
        chk("R10", {7'd0, int_n}, 8'h00);
        // R8 persistent match does not re-set
        tag = "R8";
        clear_flags(); step(); step();
        chk("R8", {7'd0, alarm_flag}, 8'h00);
        cnt_hund = 8'h13; step(); cnt_hund = 8'h12; step(); step();
        chk("R8", {7'd0, alarm_flag}, 8'h01);
        al_hour = 8'h07; clear_flags(); step();
        chk("R4", {7'd0, alarm_flag}, 8'h00);
        al_hour = 8'h87;

        // R5 weekday mask (weekday 3 in cnt_wm 0x63)
        tag = "R5";
        al_month = 8'h04; alm_ctl = 8'hA0; clear_flags(); step(); step();
        chk("R5", {7'd0, alarm_flag}, 8'h00);
        al_month = 8'h08; step(); step();
        chk("R5", {7'd0, alarm_flag}, 8'h01);

        // R6 dated alarm ignores year and weekday, honours month
        tag = "R6";
        alm_ctl = 8'hB0; al_date = 8'h15; al_month = 8'h04; clear_flags(); step();
        chk("R6", {7'd0, alarm_flag}, 8'h00);
        cnt_yd = 8'hD5; cnt_wm = 8'h04; al_month = 8'h04; step(); step();
        chk("R6", {7'd0, alarm_flag}, 8'h01);
        alm_ctl = 8'h00; clear_flags(); alm_ctl = 8'hB0; cnt_wm = 8'h05; step(); step();
        chk("R6", {7'd0, alarm_flag}, 8'h00);

        // R7 timer alarm
        tag = "R7";
        alm_ctl = 8'hC1; al_timer = 8'h05;
        tmr_wr = 1; tmr_wdata = 8'h04; step(); clear_flags();
        chk("R7", {7'd0, alarm_flag}, 8'h00);
        tick_hund = 1; step(); step();
        chk("R7", timer_q, 8'h05); chk("R7", {7'd0, alarm_flag}, 8'h01);

        // R10 enables off keep int high with flags set
        tag = "R10";
        alm_ctl = 8'h40; flag_wr = 1; flag_wdata = 2'b11; step();
        chk("R10", {7'd0, int_n}, 8'h01);
        alm_ctl = 8'h48; step();
        chk("R10", {7'd0, int_n}, 8'h00);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule